// File: doc/BRIEF.md
# Keyboard Scan-Code Controller

This block sits between a key-event source and a host processor. Each key event arrives as a 7-bit key number with a strobe and a flag that tells a release from a press. The block turns the event into a byte, queues it in a small first-in first-out buffer and holds an interrupt line high while the host has bytes to collect. The host collects one byte per read strobe.

A 2-bit mode input, taken from the two top bits of a system control port, decides how the block behaves:
- Normal operation accepts new codes.
- A muted mode drops new codes.
- A hold mode keeps the keyboard in reset.
- A full reset mode also empties the buffer.

When the full reset mode ends, a timed delay runs. When the delay runs out, the buffer is flushed and the self-test completion byte 0xAA is queued, as a real keyboard would send it after power-up.

Top module: `kbd_scan_ctrl`

## Requirements
- R1: A key event is queued as one byte: the key number goes in bits 6..0, and bit 7 is 1 for a release and 0 for a press.
- R2: In mode 2'b01 (normal), a key strobe sampled at a clock edge queues the byte when no countdown is running and the buffer is not full. At that same edge, `irq` goes high.
- R3: Modes 2'b11 (muted), 2'b10 (hold) and 2'b00 (reset) drop key strobes. At the edge where `modeBits` first takes one of these values, `irq` goes low.
- R4: While `modeBits` is 2'b00, the buffer is emptied at every edge. A read made in reset mode after that returns 8'h00.
- R5: At the edge where `modeBits` leaves 2'b00, a countdown of RESET_DELAY cycles (15 by default) starts. Key strobes are dropped while it runs. At the RESET_DELAY-th edge after the exit edge, the buffer is emptied. If the mode is 2'b01 at that edge, 8'hAA is queued and `irq` goes high.
- R6: A host read returns the oldest queued byte on `readData` after the edge that samples the read, and removes that byte. After the read, `irq` is high exactly when bytes remain queued, and this holds in every mode.
- R7: A host read with an empty buffer returns 8'h00 and leaves `irq` low.
- R8: The buffer holds DEPTH bytes (16 by default). A code that arrives while the buffer is full is dropped, and the bytes already queued are read back in order.
- R9: After reset, `irq` is 0, `readData` is 8'h00, the mode is normal, the buffer is empty and no countdown is running.
- R10: `readData` changes only at an edge that samples a host read.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rstN | input | 1 | Active-low synchronous reset |
| keyValid | input | 1 | One-cycle strobe for a key event |
| keyCode | input | 7 | Key number |
| keyReleased | input | 1 | 1 for a release, 0 for a press |
| modeBits | input | 2 | Mode: 01 normal, 11 muted, 10 hold, 00 reset |
| hostRead | input | 1 | One-cycle host read strobe |
| readData | output | 8 | Last byte read by the host |
| irq | output | 1 | High while the host has bytes to collect |

## Verification
The assertions assume three things about the inputs:
- `hostRead` and `keyValid` are one-cycle strobes.
- `modeBits` is a stable level that changes only between clock edges.
- A read strobe does not meet the edge where the countdown ends.

The read-in-reset property also assumes that nothing can enter the buffer while the mode stays at 2'b00. The bench drives every input on the falling edge and issues each strobe for exactly one cycle. It keeps reads and key events away from the final countdown edge, so the stimulus stays inside these assumptions.

// File: rtl/kbd_ctrl_pkg.sv
package kbd_ctrl_pkg;

  typedef enum logic [1:0] {
    MODE_RESET  = 2'b00,
    MODE_NORMAL = 2'b01,
    MODE_HOLD   = 2'b10,
    MODE_MUTE   = 2'b11
  } kbdModeT;

  typedef struct packed {
    logic push;       // write one byte into the queue
    logic selfTest;   // the written byte is the self-test code
    logic pop;        // drop the head byte
    logic clear;      // empty the queue (a push in the same cycle lands first)
    logic readLoad;   // update readData
  } fifoStrobeT;

  localparam logic [7:0] SELF_TEST_CODE = 8'hAA;

endpackage

// File: rtl/kbd_fifo_path.sv
module kbd_fifo_path
  import kbd_ctrl_pkg::*;
#(
  parameter int DEPTH = 16,
  parameter int WIDTH = 8
) (
  input  logic             clk,
  input  logic             rstN,
  input  fifoStrobeT       strobes,
  input  logic [WIDTH-1:0] keyByte,
  output logic [WIDTH-1:0] readData,
  output logic             fifoEmpty,
  output logic             fifoFull,
  output logic             fifoSingle
);
  localparam int AW = (DEPTH > 1) ? $clog2(DEPTH) : 1;
  localparam int CW = $clog2(DEPTH + 1);
  localparam logic [AW-1:0] LAST_PTR = AW'(DEPTH - 1);
  localparam logic [CW-1:0] FULL_CNT = CW'(DEPTH);

  logic [WIDTH-1:0] mem [DEPTH];
  logic [AW-1:0]    wrPtr, rdPtr, wrIdx;
  logic [CW-1:0]    count;
  logic [WIDTH-1:0] wrData;

  function automatic logic [AW-1:0] bump(input logic [AW-1:0] p);
    return (p == LAST_PTR) ? '0 : p + 1'b1;
  endfunction

  assign fifoEmpty  = (count == '0);
  assign fifoFull   = (count == FULL_CNT);
  assign fifoSingle = (count == CW'(1));
  assign wrIdx      = strobes.clear ? '0 : wrPtr;
  assign wrData     = strobes.selfTest ? WIDTH'(SELF_TEST_CODE) : keyByte;

  always_ff @(posedge clk) begin
    if (strobes.push) mem[wrIdx] <= wrData;
  end

  always_ff @(posedge clk) begin
    if (!rstN) begin
      wrPtr <= '0;
      rdPtr <= '0;
      count <= '0;
    end else if (strobes.clear) begin
      wrPtr <= strobes.push ? bump('0) : '0;
      rdPtr <= '0;
      count <= strobes.push ? CW'(1) : '0;
    end else begin
      if (strobes.push) wrPtr <= bump(wrPtr);
      if (strobes.pop)  rdPtr <= bump(rdPtr);
      count <= count + CW'(strobes.push) - CW'(strobes.pop);
    end
  end

  always_ff @(posedge clk) begin
    if (!rstN)                 readData <= '0;
    else if (strobes.readLoad) readData <= fifoEmpty ? '0 : mem[rdPtr];
  end

endmodule

// File: rtl/kbd_mode_ctrl.sv
module kbd_mode_ctrl
  import kbd_ctrl_pkg::*;
#(
  parameter int RESET_DELAY = 15
) (
  input  logic       clk,
  input  logic       rstN,
  input  logic       keyValid,
  input  logic [1:0] modeBits,
  input  logic       hostRead,
  input  logic       fifoEmpty,
  input  logic       fifoFull,
  input  logic       fifoSingle,
  output fifoStrobeT strobes,
  output logic       irq
);
  localparam int DW = $clog2(RESET_DELAY + 1);
  localparam logic [DW-1:0] DELAY_LOAD = DW'(RESET_DELAY);

  kbdModeT       modeQ, modeNow;
  logic [DW-1:0] delayCnt;
  logic          busy, expire, enterQuiet, leaveReset, acceptKey, injectNow;
  logic          irqNext;

  assign modeNow    = kbdModeT'(modeBits);
  assign busy       = (delayCnt != '0);
  assign expire     = (delayCnt == DW'(1)) && (modeNow != MODE_RESET);
  assign enterQuiet = (modeNow != MODE_NORMAL) && (modeNow != modeQ);
  assign leaveReset = (modeQ == MODE_RESET) && (modeNow != MODE_RESET);
  assign acceptKey  = keyValid && (modeNow == MODE_NORMAL) && !busy && !fifoFull;
  assign injectNow  = expire && (modeNow == MODE_NORMAL);

  always_comb begin
    strobes.clear    = (modeNow == MODE_RESET) || expire;
    strobes.push     = acceptKey || injectNow;
    strobes.selfTest = injectNow;
    strobes.pop      = hostRead && !fifoEmpty && !strobes.clear;
    strobes.readLoad = hostRead;
  end

  always_comb begin
    if (strobes.push)                      irqNext = 1'b1;
    else if (enterQuiet || strobes.clear)  irqNext = 1'b0;
    else if (hostRead)                     irqNext = strobes.pop && !fifoSingle;
    else                                   irqNext = irq;
  end

  always_ff @(posedge clk) begin
    if (!rstN) begin
      modeQ    <= MODE_NORMAL;
      delayCnt <= '0;
      irq      <= 1'b0;
    end else begin
      modeQ <= modeNow;
      irq   <= irqNext;
      if (modeNow == MODE_RESET) delayCnt <= '0;
      else if (leaveReset)       delayCnt <= DELAY_LOAD;
      else if (busy)             delayCnt <= delayCnt - 1'b1;
    end
  end

endmodule

// File: rtl/kbd_scan_ctrl.sv
module kbd_scan_ctrl
  import kbd_ctrl_pkg::*;
#(
  parameter int DEPTH       = 16,
  parameter int RESET_DELAY = 15
) (
  input  logic       clk,
  input  logic       rstN,
  input  logic       keyValid,
  input  logic [6:0] keyCode,
  input  logic       keyReleased,
  input  logic [1:0] modeBits,
  input  logic       hostRead,
  output logic [7:0] readData,
  output logic       irq
);
  fifoStrobeT strobes;
  logic       fifoEmpty, fifoFull, fifoSingle;
  logic [7:0] keyByte;

  assign keyByte = {keyReleased, keyCode};

  kbd_mode_ctrl #(.RESET_DELAY(RESET_DELAY)) ctrl_i (
    .clk(clk), .rstN(rstN), .keyValid(keyValid), .modeBits(modeBits),
    .hostRead(hostRead), .fifoEmpty(fifoEmpty), .fifoFull(fifoFull),
    .fifoSingle(fifoSingle), .strobes(strobes), .irq(irq)
  );

  kbd_fifo_path #(.DEPTH(DEPTH), .WIDTH(8)) path_i (
    .clk(clk), .rstN(rstN), .strobes(strobes), .keyByte(keyByte),
    .readData(readData), .fifoEmpty(fifoEmpty), .fifoFull(fifoFull),
    .fifoSingle(fifoSingle)
  );

endmodule

// File: rtl/kbd_scan_ctrl_chk.sv
module kbd_scan_ctrl_chk (
  input logic       clk,
  input logic       rstN,
  input logic       keyValid,
  input logic [1:0] modeBits,
  input logic       hostRead,
  input logic [7:0] readData,
  input logic       irq
);
  logic [1:0] prevMode;

  always_ff @(posedge clk) begin
    if (!rstN) prevMode <= 2'b01;
    else       prevMode <= modeBits;
  end

  assert_reset_state_R9: assert property (@(posedge clk) disable iff (!rstN)
    $rose(rstN) |-> (!irq && readData == 8'h00));

  assert_quiet_irq_R3: assert property (@(posedge clk) disable iff (!rstN)
    (modeBits != 2'b01 && modeBits != prevMode) |=> !irq);

  assert_reset_irq_low_R3: assert property (@(posedge clk) disable iff (!rstN)
    (modeBits == 2'b00) |=> !irq);

  assert_reset_read_zero_R4: assert property (@(posedge clk) disable iff (!rstN)
    (prevMode == 2'b00 && modeBits == 2'b00 && hostRead) |=> (readData == 8'h00));

  assert_hold_data_R10: assert property (@(posedge clk) disable iff (!rstN)
    !hostRead |=> $stable(readData));

  assert_no_key_irq_quiet_R2: assert property (@(posedge clk) disable iff (!rstN)
    (!irq && modeBits == 2'b11 && prevMode == 2'b11 && !hostRead && keyValid) |=> !irq);

endmodule

bind kbd_scan_ctrl kbd_scan_ctrl_chk chk_i (
  .clk(clk), .rstN(rstN), .keyValid(keyValid), .modeBits(modeBits),
  .hostRead(hostRead), .readData(readData), .irq(irq)
);

// File: tb/kbd_scan_ctrl_tb.sv
`timescale 1ns/1ps
module kbd_scan_ctrl_tb_top;
  logic       clk = 1'b0;
  logic       rstN;
  logic       keyValid, keyReleased, hostRead;
  logic [6:0] keyCode;
  logic [1:0] modeBits;
  logic [7:0] readData;
  logic       irq;
  int checks = 0;
  int errors = 0;

  always #2.5 clk = ~clk;

  kbd_scan_ctrl dut_i (
    .clk(clk), .rstN(rstN), .keyValid(keyValid), .keyCode(keyCode),
    .keyReleased(keyReleased), .modeBits(modeBits), .hostRead(hostRead),
    .readData(readData), .irq(irq)
  );

  task automatic check(input string req, input string what,
                       input logic [7:0] act, input logic [7:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s %s act=%02h exp=%02h", req, what, act, exp);
    end
  endtask

  task automatic sendKey(input logic [6:0] code, input logic rel);
    @(negedge clk);
    keyValid = 1'b1; keyCode = code; keyReleased = rel;
    @(negedge clk);
    keyValid = 1'b0;
  endtask

  task automatic readOne(output logic [7:0] data, output logic irqAfter);
    @(negedge clk);
    hostRead = 1'b1;
    @(negedge clk);
    hostRead = 1'b0;
    data = readData;
    irqAfter = irq;
  endtask

  task automatic setMode(input logic [1:0] m);
    @(negedge clk);
    modeBits = m;
    @(negedge clk);
  endtask

  task automatic tResetState();
    check("R9", "irq", {7'd0, irq}, 8'h00);
    check("R9", "readData", readData, 8'h00);
  endtask

  task automatic tPressRelease();
    logic [7:0] d; logic i;
    sendKey(7'h1C, 1'b0);
    check("R2", "irq after press", {7'd0, irq}, 8'h01);
    readOne(d, i);
    check("R1", "press byte", d, 8'h1C);
    check("R6", "irq after last read", {7'd0, i}, 8'h00);
    sendKey(7'h1C, 1'b1);
    readOne(d, i);
    check("R1", "release byte", d, 8'h9C);
    repeat (3) @(negedge clk);
    check("R10", "readData held", readData, 8'h9C);
  endtask

  task automatic tQuietModes();
    logic [7:0] d; logic i;
    sendKey(7'h21, 1'b0);
    sendKey(7'h22, 1'b1);
    setMode(2'b11);
    check("R3", "irq low in muted", {7'd0, irq}, 8'h00);
    sendKey(7'h33, 1'b0);
    check("R3", "muted key no irq", {7'd0, irq}, 8'h00);
    readOne(d, i);
    check("R6", "first byte", d, 8'h21);
    check("R6", "irq re-raised", {7'd0, i}, 8'h01);
    setMode(2'b10);
    check("R3", "irq low in hold", {7'd0, irq}, 8'h00);
    readOne(d, i);
    check("R6", "second byte", d, 8'hA2);
    check("R6", "irq after drain", {7'd0, i}, 8'h00);
    readOne(d, i);
    check("R7", "empty read", d, 8'h00);
    check("R7", "empty read irq", {7'd0, i}, 8'h00);
    setMode(2'b01);
  endtask

  task automatic tResetClear();
    logic [7:0] d; logic i;
    sendKey(7'h05, 1'b0);
    sendKey(7'h06, 1'b0);
    setMode(2'b00);
    check("R3", "irq low in reset", {7'd0, irq}, 8'h00);
    readOne(d, i);
    check("R4", "read in reset", d, 8'h00);
  endtask

  task automatic tSelfTest();
    logic [7:0] d; logic i;
    @(negedge clk);
    modeBits = 2'b01;              // exit edge follows
    repeat (5) @(negedge clk);     // now after edge 4
    keyValid = 1'b1; keyCode = 7'h10; keyReleased = 1'b0;
    @(negedge clk);
    keyValid = 1'b0;               // dropped at edge 5
    repeat (9) @(negedge clk);     // after edge 14
    check("R5", "irq before expiry", {7'd0, irq}, 8'h00);
    @(negedge clk);                // after edge 15
    check("R5", "irq at expiry", {7'd0, irq}, 8'h01);
    readOne(d, i);
    check("R5", "self-test byte", d, 8'hAA);
    check("R5", "only self-test queued", {7'd0, i}, 8'h00);
  endtask

  task automatic tOverflow();
    logic [7:0] d; logic i;
    for (int k = 0; k < 17; k++) sendKey(7'(k + 1), 1'b0);
    for (int k = 0; k < 16; k++) begin
      readOne(d, i);
      check("R8", "fifo order", d, 8'(k + 1));
    end
    check("R8", "irq after 16 reads", {7'd0, i}, 8'h00);
    readOne(d, i);
    check("R8", "17th dropped", d, 8'h00);
  endtask

  initial begin
    rstN = 1'b0; keyValid = 1'b0; keyReleased = 1'b0; keyCode = '0;
    hostRead = 1'b0; modeBits = 2'b01;
    repeat (3) @(negedge clk);
    rstN = 1'b1;
    @(negedge clk);
    tResetState();
    tPressRelease();
    tQuietModes();
    tResetClear();
    tSelfTest();
    tOverflow();
    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end

  initial begin
    #500000;
    checks++;
    errors++;
    $display("FAIL watchdog act=01 exp=00");
    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end

endmodule